// File: doc/BRIEF.md
# Reference Divider, Phase Detector and Lock Detector

This block is the digital core of a frequency synthesiser loop. It is clocked by the reference clock, which it divides by a power of two chosen with a three-bit select to form the comparison frequency. A phase/frequency detector compares the comparison frequency with the output of an external feedback divider and produces up and down controls for an analog charge pump. A lock detector watches the width of those pulses and drives an open-drain style lock indication.

The block also applies the loop controls: a charge-pump disable input that tri-states the pump, a drive-off control that releases the tuning-line driver so the line can be driven from outside, and a current-select bit passed to the pump. A test mode puts the comparison frequency and the feedback signal divided by two on the two lowest port pins. Enabling test mode while the pump is disabled is not allowed. In that case the block keeps normal operation, ignores test mode and sets a sticky error flag.

Top module: `cmp_lock_core`

## Requirements
- R1: With select value S (0 to 7) on `ratio_sel`, the comparison signal has a period of 2^(S+1) clock cycles (S=0 gives 2, S=7 gives 256). In test mode the period is visible on `port_drv[1]`.
- R2: The detector is frequency sensitive. With no rising edges on `fb_div`, `pump_up` stays high and `pump_dn` stays low. When `fb_div` rises far more often than the comparison signal, `pump_dn` is high for most cycles.
- R3: When `pump_up` and `pump_dn` are both high in a cycle, both are low in the next cycle. This is the detector's reset pulse.
- R4: `pump_oe` is the registered inverse of `pump_dis`, so it is 0 (pump high impedance) one cycle after `pump_dis`=1.
- R5: `drive_en` is the registered inverse of `drive_off`. `cur_sel` is the registered copy of `cur_hi` (0 = low pump current, 1 = high pump current).
- R6: `lock_pull`=1 means the lock pin sinks current (out of lock), and 0 means high impedance (in lock). Lock is declared after LOCK_CNT consecutive comparison periods in which no up or down pulse was active for more than LOCK_WIN cycles in a row.
- R7: An up or down pulse active for more than LOCK_WIN consecutive cycles sets `lock_pull` to 1 on the next clock edge.
- R8: Test mode is active when `test_en`=1, `drive_off`=0 and `pump_dis`=0. In test mode `port_drv[0]` toggles on each rising edge of `fb_div` (one registered stage after the edge is seen) and `port_drv[1]` carries the comparison signal. In every other case each `port_drv[i]` is the registered `port_bits[i]`. Pins 2 and up always follow `port_bits`.
- R9: When `test_en`=1 and `pump_dis`=1, the ports follow `port_bits`, and `cfg_err` goes to 1 one cycle later and stays there until reset.
- R10: During reset `pump_up`, `pump_dn`, `pump_oe`, `drive_en`, `cur_sel`, `port_drv` and `cfg_err` are 0 and `lock_pull` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | SEL_W | Reference division select, ratio 2^(S+1) |
| fb_div | input | 1 | Feedback divider output (level) |
| pump_dis | input | 1 | Charge-pump disable |
| drive_off | input | 1 | Tuning-line drive disable |
| cur_hi | input | 1 | Pump current select |
| test_en | input | 1 | Test-mode request |
| port_bits | input | PORT_N | Port pin values for normal mode |
| pump_up | output | 1 | Pump up control |
| pump_dn | output | 1 | Pump down control |
| pump_oe | output | 1 | Pump output enable (0 = high impedance) |
| drive_en | output | 1 | Tuning-line driver enable |
| cur_sel | output | 1 | Pump current level |
| lock_pull | output | 1 | Lock pin pull-down (0 = high impedance, in lock) |
| port_drv | output | PORT_N | Port pin drive |
| cfg_err | output | 1 | Sticky forbidden-combination flag |

## Verification
Assertions check several rules on every cycle: the simultaneous clearing of both detector flops, the divider count staying below its current terminal value, lock being declared only at a comparison edge, lock being dropped after an over-wide pulse, the pump output enable following its disable, and the error flag being set and then held. Only the bench scenarios can show the division ratios as measured periods, frequency-sensitive detector behaviour with a stopped or fast feedback signal, and the feedback halving on the test port. They also show lock being gained with a feedback signal aligned to the comparison edges and lost after a half-period phase shift.

// File: rtl/cl_pkg.sv
package cl_pkg;

  typedef struct packed {
    logic pump_dis;
    logic drive_off;
    logic cur_hi;
    logic test_en;
  } loop_ctl_t;

endpackage

// File: rtl/cl_ref_div.sv
module cl_ref_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             comp,
  output logic             ref_ev
);
  localparam int NSEL     = 1 << SEL_W;
  localparam int HALF_MAX = 1 << (NSEL - 1);
  localparam int CNT_W    = $clog2(HALF_MAX) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  // half period minus one: 2^sel - 1
  assign half_m1 = (CNT_W'(1) << sel) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      comp   <= 1'b0;
      ref_ev <= 1'b0;
    end else if (cnt >= half_m1) begin
      cnt    <= '0;
      comp   <= ~comp;
      ref_ev <= ~comp;
    end else begin
      cnt    <= cnt + 1'b1;
      ref_ev <= 1'b0;
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == sel) |-> (cnt <= half_m1));

endmodule

// File: rtl/cl_pfd.sv
module cl_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_ev,
  input  logic fb_div,
  output logic up,
  output logic dn,
  output logic fb_half
);
  logic fb_s1, fb_s2, fb_ev, clr;

  assign fb_ev = fb_s1 & ~fb_s2;
  assign clr   = up & dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_s1   <= 1'b0;
      fb_s2   <= 1'b0;
      fb_half <= 1'b0;
    end else begin
      fb_s1 <= fb_div;
      fb_s2 <= fb_s1;
      if (fb_ev) fb_half <= ~fb_half;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (clr) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | ref_ev;
      dn <= dn | fb_ev;
    end
  end

  // R3
  both_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!up && !dn));

endmodule

// File: rtl/cl_lock_det.sv
module cl_lock_det #(
  parameter int LOCK_WIN = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic up,
  input  logic dn,
  input  logic ref_ev,
  output logic locked
);
  localparam int WC_W = $clog2(LOCK_WIN + 2);
  localparam int GC_W = $clog2(LOCK_CNT + 1);

  logic            active, wide, bad;
  logic [WC_W-1:0] wcnt;
  logic [GC_W-1:0] good;

  assign active = up | dn;
  assign wide   = active && (wcnt >= WC_W'(LOCK_WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
    end else if (!active) begin
      wcnt <= '0;
    end else if (wcnt <= WC_W'(LOCK_WIN)) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good   <= '0;
      bad    <= 1'b0;
      locked <= 1'b0;
    end else if (ref_ev) begin
      bad <= 1'b0;
      if (bad || wide) begin
        good   <= '0;
        locked <= 1'b0;
      end else begin
        if (good < GC_W'(LOCK_CNT)) good <= good + 1'b1;
        if (good >= GC_W'(LOCK_CNT - 1)) locked <= 1'b1;
      end
    end else if (wide) begin
      bad    <= 1'b1;
      good   <= '0;
      locked <= 1'b0;
    end
  end

  // R6
  lock_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_ev));

  // R7
  wide_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (active && wcnt >= WC_W'(LOCK_WIN)) |=> !locked);

endmodule

// File: rtl/cl_port_mux.sv
module cl_port_mux
  import cl_pkg::*;
#(
  parameter int PORT_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  loop_ctl_t         ctl,
  input  logic [PORT_N-1:0] port_bits,
  input  logic              comp,
  input  logic              fb_half,
  output logic [PORT_N-1:0] port_drv,
  output logic              pump_oe,
  output logic              drive_en,
  output logic              cur_sel,
  output logic              cfg_err
);
  logic              test_act, forbid;
  logic [PORT_N-1:0] nxt;

  assign forbid   = ctl.test_en & ctl.pump_dis;
  assign test_act = ctl.test_en & ~ctl.pump_dis & ~ctl.drive_off;

  for (genvar i = 0; i < PORT_N; i++) begin : g_pin
    if (i == 0) begin : g_p0
      assign nxt[i] = test_act ? fb_half : port_bits[i];
    end else if (i == 1) begin : g_p1
      assign nxt[i] = test_act ? comp : port_bits[i];
    end else begin : g_pn
      assign nxt[i] = port_bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_drv <= '0;
      pump_oe  <= 1'b0;
      drive_en <= 1'b0;
      cur_sel  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      port_drv <= nxt;
      pump_oe  <= ~ctl.pump_dis;
      drive_en <= ~ctl.drive_off;
      cur_sel  <= ctl.cur_hi;
      if (forbid) cfg_err <= 1'b1;
    end
  end

  // R4
  pump_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.pump_dis |=> !pump_oe);

  // R5
  drive_release_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.drive_off |=> !drive_en);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    forbid |=> cfg_err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R8
  normal_pin1_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.test_en |=> (port_drv[1] == $past(port_bits[1])));

endmodule

// File: rtl/cmp_lock_core.sv
module cmp_lock_core
  import cl_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int PORT_N   = 4,
  parameter int LOCK_WIN = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  ratio_sel,
  input  logic              fb_div,
  input  logic              pump_dis,
  input  logic              drive_off,
  input  logic              cur_hi,
  input  logic              test_en,
  input  logic [PORT_N-1:0] port_bits,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_oe,
  output logic              drive_en,
  output logic              cur_sel,
  output logic              lock_pull,
  output logic [PORT_N-1:0] port_drv,
  output logic              cfg_err
);
  logic      comp, ref_ev, fb_half, locked;
  loop_ctl_t ctl;

  assign ctl.pump_dis  = pump_dis;
  assign ctl.drive_off = drive_off;
  assign ctl.cur_hi    = cur_hi;
  assign ctl.test_en   = test_en;

  cl_ref_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .sel(ratio_sel), .comp(comp), .ref_ev(ref_ev)
  );

  cl_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_ev(ref_ev), .fb_div(fb_div),
    .up(pump_up), .dn(pump_dn), .fb_half(fb_half)
  );

  cl_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst(rst), .up(pump_up), .dn(pump_dn), .ref_ev(ref_ev),
    .locked(locked)
  );

  cl_port_mux #(.PORT_N(PORT_N)) u_mux (
    .clk(clk), .rst(rst), .ctl(ctl), .port_bits(port_bits), .comp(comp),
    .fb_half(fb_half), .port_drv(port_drv), .pump_oe(pump_oe),
    .drive_en(drive_en), .cur_sel(cur_sel), .cfg_err(cfg_err)
  );

  assign lock_pull = ~locked;

endmodule

// File: tb/sim_cmp_lock_core.sv
module sim_cmp_lock_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_sel = '0;
  logic       fb_div = 1'b0;
  logic       pump_dis = 1'b0, drive_off = 1'b0, cur_hi = 1'b0, test_en = 1'b0;
  logic [3:0] port_bits = '0;
  logic       pump_up, pump_dn, pump_oe, drive_en, cur_sel, lock_pull, cfg_err;
  logic [3:0] port_drv;

  int n_chk = 0, n_fail = 0, ncyc = 0;
  int fb_run = 0, fb_per = 16, fb_ph = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_lock_core u0 (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .fb_div(fb_div),
    .pump_dis(pump_dis), .drive_off(drive_off), .cur_hi(cur_hi),
    .test_en(test_en), .port_bits(port_bits), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .drive_en(drive_en),
    .cur_sel(cur_sel), .lock_pull(lock_pull), .port_drv(port_drv),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) ncyc <= ncyc + 1;

  // feedback waveform generator: period fb_per, rising at phase fb_ph
  always @(negedge clk)
    fb_div <= (fb_run != 0) &&
              (((ncyc - fb_ph + 1000 * fb_per) % fb_per) < fb_per / 2);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  // cycles between two rising edges of port_drv[idx]
  task automatic period(input int idx, output int per);
    int t0;
    logic prev;
    per = -1;
    t0 = -1;
    prev = port_drv[idx];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (port_drv[idx] && !prev) begin
        if (t0 < 0) t0 = ncyc;
        else begin
          per = ncyc - t0;
          break;
        end
      end
      prev = port_drv[idx];
    end
  endtask

  function automatic bit test_on(bit t, bit os, bit dis);
    return t && !os && !dis;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int per, dn_cnt, both_bad, c0, run, seen;
    bit exp_err, t, os, dis, ch;
    logic [3:0] pb;
    logic prev;
    void'($urandom(32'd4242));

    // R10 reset state
    step(3);
    chk("R10 pump_up", int'(pump_up), 0);
    chk("R10 pump_dn", int'(pump_dn), 0);
    chk("R10 pump_oe", int'(pump_oe), 0);
    chk("R10 drive_en", int'(drive_en), 0);
    chk("R10 lock_pull", int'(lock_pull), 1);
    chk("R10 port_drv", int'(port_drv), 0);
    chk("R10 cfg_err", int'(cfg_err), 0);
    rst = 1'b0;

    // R4 / R5 directed
    step(1);
    chk("R4 pump_oe on", int'(pump_oe), 1);
    pump_dis = 1'b1; drive_off = 1'b1; cur_hi = 1'b1;
    step(1);
    chk("R4 pump_oe off", int'(pump_oe), 0);
    chk("R5 drive_en off", int'(drive_en), 0);
    chk("R5 cur_sel high", int'(cur_sel), 1);
    pump_dis = 1'b0; drive_off = 1'b0; cur_hi = 1'b0;
    step(1);
    chk("R5 drive_en on", int'(drive_en), 1);
    chk("R5 cur_sel low", int'(cur_sel), 0);

    // R1 every division ratio, seen on port_drv[1] in test mode
    test_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      ratio_sel = 3'(s);
      step(8);
      period(1, per);
      chk($sformatf("R1 ratio sel=%0d", s), per, 1 << (s + 1));
    end

    // R8 feedback halved on port_drv[0], upper pins follow bits
    fb_per = 8; fb_ph = 0; fb_run = 1;
    step(20);
    period(0, per);
    chk("R8 pin0 period", per, 16);
    port_bits = 4'b1100;
    step(2);
    chk("R8 upper pins", int'(port_drv[3:2]), 3);

    // R2 frequency sensitivity
    fb_run = 0; test_en = 1'b0; ratio_sel = 3'd3; port_bits = '0;
    do_reset();
    step(40);
    chk("R2 up held, no feedback", int'(pump_up), 1);
    chk("R2 dn low, no feedback", int'(pump_dn), 0);
    ratio_sel = 3'd7; fb_per = 2; fb_ph = 0; fb_run = 1;
    step(600);
    dn_cnt = 0; both_bad = 0; prev = 1'b0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (pump_dn) dn_cnt++;
      if (prev && (pump_up || pump_dn)) both_bad++;
      prev = pump_up && pump_dn;
    end
    chk("R2 dn dominant", int'(dn_cnt > 400), 1);
    chk("R3 reset pulse", both_bad, 0);

    // R6 lock with aligned feedback
    fb_run = 0; ratio_sel = 3'd3; test_en = 1'b1;
    do_reset();
    step(2);
    chk("R6 unlocked at start", int'(lock_pull), 1);
    c0 = -1;
    prev = port_drv[1];
    for (int i = 0; i < 100 && c0 < 0; i++) begin
      @(negedge clk);
      if (port_drv[1] && !prev) c0 = ncyc;
      prev = port_drv[1];
    end
    fb_per = 16; fb_ph = c0; fb_run = 1;
    step(16 * 12);
    chk("R6 locked when aligned", int'(lock_pull), 0);

    // R7 half-period shift: lock dropped right after a wide pulse
    fb_ph = c0 + 8;
    run = 0; seen = 0;
    for (int i = 0; i < 64 && seen == 0; i++) begin
      @(negedge clk);
      if (run >= 5) begin
        chk("R7 lock dropped after wide pulse", int'(lock_pull), 1);
        seen = 1;
      end
      run = (pump_up || pump_dn) ? run + 1 : 0;
    end
    chk("R7 wide pulse observed", seen, 1);

    // R8 / R9 / R4 / R5 random control patterns
    fb_run = 0;
    do_reset();
    exp_err = 1'b0;
    for (int k = 0; k < 300; k++) begin
      t = 1'($urandom); os = 1'($urandom); dis = 1'($urandom);
      ch = 1'($urandom); pb = 4'($urandom);
      test_en = t; drive_off = os; pump_dis = dis; cur_hi = ch;
      port_bits = pb;
      if (t && dis) exp_err = 1'b1;
      step(1);
      chk("R4 pump_oe", int'(pump_oe), int'(!dis));
      chk("R5 drive_en", int'(drive_en), int'(!os));
      chk("R5 cur_sel", int'(cur_sel), int'(ch));
      chk("R8 upper pins", int'(port_drv[3:2]), int'(pb[3:2]));
      if (!test_on(t, os, dis))
        chk(t ? "R9 low pins ignore test" : "R8 low pins normal",
            int'(port_drv[1:0]), int'(pb[1:0]));
      chk("R9 cfg_err", int'(cfg_err), int'(exp_err));
    end

    // R9 forbidden combination directed, then cleared by reset
    test_en = 1'b1; pump_dis = 1'b1; drive_off = 1'b0; port_bits = 4'b0010;
    step(2);
    chk("R9 forbidden pins", int'(port_drv[1:0]), 2);
    chk("R9 forbidden flag", int'(cfg_err), 1);
    test_en = 1'b0; pump_dis = 1'b0;
    step(2);
    chk("R9 flag sticky", int'(cfg_err), 1);
    do_reset();
    step(1);
    chk("R9 flag cleared by reset", int'(cfg_err), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule